// File: doc/BRIEF.md
# Level-Shifted Carrier Gate Controller for a Nine-Level Inverter Leg

This block produces the switch commands for one leg of a stepped-voltage inverter whose input stage is a stack of four equal DC sources. Five level switches pick how many of those sources feed a polarity-reversing H-bridge (none, one, two, three or four), and the bridge then puts that magnitude across the load with either sign. Together they give nine output steps, from minus four to plus four units.

A prescaler off the system clock makes a sample tick. On every tick the block reads the next point of a computed half-wave reference (one full period spans a fixed number of samples) and the next point of a triangle carrier. The reference magnitude is scaled by a modulation-index input, then compared against four copies of the carrier stacked one above the other. The number of carriers it exceeds is the level, and only that one level switch is turned on. The sign of the reference chooses the bridge diagonal. The bridge changes over only while the level is zero, so in normal operation it switches once per half-cycle and is never pulse-modulated. With the default parameters and a 50 MHz clock, the tick runs at 50 kHz, the reference at 50 Hz (1000 samples) and the carrier at 2 kHz (25 samples).

Top module: `mlpwm_level_ctrl`

## Requirements
- R1: While reset is asserted, and after release until the first gate update, the level gates read 5'b00001 and all four bridge gates are off.
- R2: A sample tick occurs once every TICK_DIV clocks, counted from reset release (the first on the TICK_DIV-th clock). Each tick captures the current reference index (0 to SINE_PTS-1) and carrier index (0 to TRI_PTS-1), and then advances each index by one with wrap-around. The first captured pair is (0, 0).
- R3: With H = SINE_PTS/2 and half-index h = i mod H, the reference magnitude is floor(16*CAR_MAX*h*(H-h)/(H*H)). The sign is negative when i >= H.
- R4: The carrier value for index j is floor(CAR_MAX*|2j - TRI_PTS| / TRI_PTS).
- R5: The modulation index is sampled on the tick and clamped to 256 (full scale, with MI_W = 9). The scaled magnitude is floor(magnitude*index/256), so any index above 256 acts exactly as 256, and an index of 0 holds the level at 0.
- R6: The level equals the count of k in {0,1,2,3} for which the scaled magnitude is strictly greater than k*CAR_MAX + carrier. It therefore never exceeds 4.
- R7: The level gates are one-hot at all times. Bit 0 is the zero-level bypass switch, and bit k is the tap switch for k sources.
- R8: Once started, exactly two bridge gates are on. Bit order is {low-right, high-right, low-left, high-left}. Positive polarity gives 4'b1001 and negative gives 4'b0110.
- R9: The bridge polarity takes the reference sign only on a gate update whose level is 0. Over one full reference period at full modulation it changes exactly twice.
- R10: All gates change only on the clock edge that follows a tick edge, and they hold their value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mod_idx | input | MI_W | Modulation index, 256 = full scale, larger values clamp |
| lvl_gate | output | 5 | One-hot level switch commands, bit k = k sources |
| br_gate | output | 4 | Bridge commands {low-right, high-right, low-left, high-left} |

## Verification
The tick fires on the TICK_DIV-th clock after reset release. The tick edge captures the indices and the modulation index into registers, and the gates take their new value one edge later. The first visible update therefore arrives TICK_DIV+1 clocks after release. The bench model advances its own integer prescaler, index and sample state on every rising edge, with the same one-edge gap between capture and gate update. It compares both gate buses at each falling edge, so no result depends on the order of processes at the clock edge. Each scenario starts from a fresh reset so that a whole reference period is known to fit in the run. The scenarios include full, half, zero and over-range modulation, and an index that changes between ticks.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  // Bridge polarity held between zero-level crossings.
  typedef enum logic {
    POL_POS = 1'b0,
    POL_NEG = 1'b1
  } pol_e;

  // Number of source taps, and so number of stacked carriers.
  localparam int NUM_TAPS = 4;
  localparam int LVL_W    = 3;

  // Bridge gate patterns, bits {low-right, high-right, low-left, high-left}.
  localparam logic [3:0] BR_OFF = 4'b0000;
  localparam logic [3:0] BR_POS = 4'b1001;
  localparam logic [3:0] BR_NEG = 4'b0110;

endpackage

// File: rtl/mlpwm_tick_gen.sv
module mlpwm_tick_gen #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  assign tick = (cnt_q == CW'(TICK_DIV - 1));

  always_comb begin
    cnt_nx = cnt_q + 1'b1;
    if (tick) cnt_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/mlpwm_ref_tables.sv
module mlpwm_ref_tables #(
  parameter int SINE_PTS = 1000,
  parameter int TRI_PTS  = 25,
  parameter int CAR_MAX  = 250,
  parameter int MI_W     = 9,
  localparam int MAG_W   = $clog2(4 * CAR_MAX + 1),
  localparam int CAR_W   = $clog2(CAR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [MI_W-1:0]  mod_idx,
  output logic             upd,
  output logic [MAG_W-1:0] mag,
  output logic [CAR_W-1:0] car,
  output logic             neg
);
  localparam int HALF   = SINE_PTS / 2;
  localparam int SW     = $clog2(SINE_PTS);
  localparam int TW     = $clog2(TRI_PTS);
  localparam int MI_ONE = 1 << (MI_W - 1);

  logic [SW-1:0]   si_q, si_nx, ssi_q, ssi_nx;
  logic [TW-1:0]   ti_q, ti_nx, sti_q, sti_nx;
  logic [MI_W-1:0] smi_q, smi_nx, mi_sat;
  logic            upd_q;

  // Clamp the index to full scale before it is captured.
  assign mi_sat = (mod_idx > MI_W'(MI_ONE)) ? MI_W'(MI_ONE) : mod_idx;

  always_comb begin
    si_nx  = si_q;
    ti_nx  = ti_q;
    ssi_nx = ssi_q;
    sti_nx = sti_q;
    smi_nx = smi_q;
    if (tick) begin
      ssi_nx = si_q;
      sti_nx = ti_q;
      smi_nx = mi_sat;
      si_nx  = (si_q == SW'(SINE_PTS - 1)) ? '0 : si_q + 1'b1;
      ti_nx  = (ti_q == TW'(TRI_PTS - 1))  ? '0 : ti_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q  <= '0;
      ti_q  <= '0;
      ssi_q <= '0;
      sti_q <= '0;
      smi_q <= '0;
      upd_q <= 1'b0;
    end else begin
      si_q  <= si_nx;
      ti_q  <= ti_nx;
      ssi_q <= ssi_nx;
      sti_q <= sti_nx;
      smi_q <= smi_nx;
      upd_q <= tick;
    end
  end

  // Computed tables: half-wave arch for the reference, folded ramp for the carrier.
  logic [31:0] h32, par32, sc32, j2, d32, tri32;

  always_comb begin
    h32   = (ssi_q >= SW'(HALF)) ? 32'(ssi_q) - 32'(HALF) : 32'(ssi_q);
    par32 = (32'(16 * CAR_MAX) * h32 * (32'(HALF) - h32)) / 32'(HALF * HALF);
    sc32  = (par32 * 32'(smi_q)) >> (MI_W - 1);
    j2    = 32'(sti_q) << 1;
    d32   = (j2 >= 32'(TRI_PTS)) ? j2 - 32'(TRI_PTS) : 32'(TRI_PTS) - j2;
    tri32 = (32'(CAR_MAX) * d32) / 32'(TRI_PTS);
  end

  assign mag = sc32[MAG_W-1:0];
  assign car = tri32[CAR_W-1:0];
  assign neg = (ssi_q >= SW'(HALF));
  assign upd = upd_q;
endmodule

// File: rtl/mlpwm_level_sel.sv
module mlpwm_level_sel
  import mlpwm_pkg::*;
#(
  parameter int CAR_MAX = 250,
  parameter int MAG_W   = 10,
  parameter int CAR_W   = 8
) (
  input  logic [MAG_W-1:0]  mag,
  input  logic [CAR_W-1:0]  car,
  output logic [LVL_W-1:0]  lvl_idx,
  output logic [NUM_TAPS:0] lvl_oh
);
  localparam int CMP_W = MAG_W + 1;

  logic [NUM_TAPS-1:0] above;

  // One comparator per stacked carrier band.
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_band
    logic [CMP_W-1:0] thr;
    assign thr      = CMP_W'(k * CAR_MAX) + CMP_W'(car);
    assign above[k] = (CMP_W'(mag) > thr);
  end

  always_comb begin
    lvl_idx = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      lvl_idx = lvl_idx + LVL_W'(above[k]);
    end
  end

  for (genvar j = 0; j <= NUM_TAPS; j++) begin : g_dec
    assign lvl_oh[j] = (lvl_idx == LVL_W'(j));
  end
endmodule

// File: rtl/mlpwm_bridge_ctl.sv
module mlpwm_bridge_ctl
  import mlpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic       lvl_zero,
  input  logic       neg,
  output logic [3:0] br_gate
);
  logic on_q, on_nx;
  pol_e pol_q, pol_nx;

  always_comb begin
    on_nx  = on_q;
    pol_nx = pol_q;
    if (upd) begin
      on_nx = 1'b1;
      if (lvl_zero) pol_nx = neg ? POL_NEG : POL_POS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      pol_q <= POL_POS;
    end else begin
      on_q  <= on_nx;
      pol_q <= pol_nx;
    end
  end

  always_comb begin
    br_gate = BR_OFF;
    if (on_q) br_gate = (pol_q == POL_NEG) ? BR_NEG : BR_POS;
  end
endmodule

// File: rtl/mlpwm_level_ctrl.sv
module mlpwm_level_ctrl
  import mlpwm_pkg::*;
#(
  parameter int TICK_DIV = 1000,
  parameter int SINE_PTS = 1000,
  parameter int TRI_PTS  = 25,
  parameter int CAR_MAX  = 250,
  parameter int MI_W     = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MI_W-1:0]     mod_idx,
  output logic [NUM_TAPS:0]   lvl_gate,
  output logic [3:0]          br_gate
);
  localparam int MAG_W = $clog2(4 * CAR_MAX + 1);
  localparam int CAR_W = $clog2(CAR_MAX + 1);

  logic             tick;
  logic             upd;
  logic [MAG_W-1:0] mag;
  logic [CAR_W-1:0] car;
  logic             neg;
  logic [LVL_W-1:0] lvl_idx;
  logic [NUM_TAPS:0] lvl_oh;
  logic [NUM_TAPS:0] lvl_q, lvl_nx;

  mlpwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  mlpwm_ref_tables #(
    .SINE_PTS(SINE_PTS), .TRI_PTS(TRI_PTS), .CAR_MAX(CAR_MAX), .MI_W(MI_W)
  ) u_ref (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mod_idx(mod_idx),
    .upd(upd), .mag(mag), .car(car), .neg(neg)
  );

  mlpwm_level_sel #(.CAR_MAX(CAR_MAX), .MAG_W(MAG_W), .CAR_W(CAR_W)) u_sel (
    .mag(mag), .car(car), .lvl_idx(lvl_idx), .lvl_oh(lvl_oh)
  );

  mlpwm_bridge_ctl u_br (
    .clk(clk), .rst_n(rst_n), .upd(upd),
    .lvl_zero(lvl_idx == '0), .neg(neg), .br_gate(br_gate)
  );

  always_comb begin
    lvl_nx = lvl_q;
    if (upd) lvl_nx = lvl_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= (NUM_TAPS+1)'(1);
    else        lvl_q <= lvl_nx;
  end

  assign lvl_gate = lvl_q;
endmodule

// File: rtl/mlpwm_level_ctrl_chk.sv
module mlpwm_level_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd,
  input logic [4:0] lvl_gate,
  input logic [3:0] br_gate
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_LVL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lvl_gate) == 1); // R7

  AST_BR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (br_gate != 4'b0000) |-> (br_gate == 4'b1001 || br_gate == 4'b0110)); // R8

  AST_BR_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(br_gate) != 4'b0000) |-> (br_gate != 4'b0000)); // R8

  AST_BR_FLIP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(br_gate) != 4'b0000 && br_gate != $past(br_gate)) |-> lvl_gate[0]); // R9

  AST_GATE_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && (lvl_gate != $past(lvl_gate) || br_gate != $past(br_gate))) |-> $past(upd)); // R10
endmodule

bind mlpwm_level_ctrl mlpwm_level_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .lvl_gate(lvl_gate), .br_gate(br_gate)
);

// File: tb/mlpwm_level_ctrl_test.sv
`timescale 1ns/1ps
module mlpwm_level_ctrl_test;
  localparam int DIV = 4;
  localparam int SP  = 1000;
  localparam int TP  = 25;
  localparam int C   = 250;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] mod_idx = '0;
  logic [4:0] lvl_gate;
  logic [3:0] br_gate;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mlpwm_level_ctrl #(.TICK_DIV(DIV), .SINE_PTS(SP), .TRI_PTS(TP), .CAR_MAX(C), .MI_W(9)) uut (
    .clk(clk), .rst_n(rst_n), .mod_idx(mod_idx), .lvl_gate(lvl_gate), .br_gate(br_gate)
  );

  // Requirement formulas R3 R4 R5 R6
  function automatic int ref_level(int i, int j, int mi);
    int h, m, s, t, n;
    h = i % (SP / 2);
    m = (16 * C * h * (SP / 2 - h)) / ((SP / 2) * (SP / 2));
    s = (m * mi) / 256;
    t = (C * ((2 * j >= TP) ? 2 * j - TP : TP - 2 * j)) / TP;
    n = 0;
    for (int k = 0; k < 4; k++) if (s > k * C + t) n++;
    return n;
  endfunction

  // Behavioural model, stepped on every rising edge.
  int m_cnt, m_si, m_ti, m_ssi, m_sti, m_smi;
  bit m_upd, m_on, m_neg;
  logic [4:0] exp_lvl;
  logic [3:0] exp_br;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_si = 0; m_ti = 0; m_ssi = 0; m_sti = 0; m_smi = 0;
      m_upd = 0; m_on = 0; m_neg = 0;
      exp_lvl = 5'b00001; exp_br = 4'b0000;
    end else begin
      bit tk;
      tk = (m_cnt == DIV - 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      if (m_upd) begin
        int lv;
        lv = ref_level(m_ssi, m_sti, m_smi);
        exp_lvl = 5'(1 << lv);
        if (lv == 0) m_neg = (m_ssi >= SP / 2);
        m_on = 1;
        exp_br = m_neg ? 4'b0110 : 4'b1001;
      end
      m_upd = tk;
      if (tk) begin
        m_ssi = m_si; m_sti = m_ti;
        m_smi = (int'(mod_idx) > 256) ? 256 : int'(mod_idx);
        m_si = (m_si + 1) % SP; m_ti = (m_ti + 1) % TP;
      end
    end
  end

  // Per-cycle comparison and run statistics.
  int maxlvl, toggles;
  logic [3:0] prev_br;

  function automatic int lvl_of(logic [4:0] g);
    for (int k = 0; k < 5; k++) if (g[k]) return k;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (lvl_gate !== exp_lvl) begin
        errors++;
        $display("FAIL R2 R3 R4 R6 R10 lvl_gate actual %b expected %b at %0t", lvl_gate, exp_lvl, $time);
      end
      checks++;
      if (br_gate !== exp_br) begin
        errors++;
        $display("FAIL R8 R9 R10 br_gate actual %b expected %b at %0t", br_gate, exp_br, $time);
      end
      checks++;
      if ($countones(lvl_gate) != 1) begin
        errors++;
        $display("FAIL R7 lvl_gate actual %b expected one-hot", lvl_gate);
      end
      if (lvl_of(lvl_gate) > maxlvl) maxlvl = lvl_of(lvl_gate);
      if (prev_br != 4'b0000 && br_gate != prev_br) toggles++;
      prev_br = br_gate;
    end
  end

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset lvl_gate", int'(lvl_gate), 1);
    check_eq("R1 reset br_gate", int'(br_gate), 0);
    maxlvl = 0; toggles = 0; prev_br = 4'b0000;
    rst_n = 1'b1;
  endtask

  localparam int RUN = SP * DIV + 4 * DIV;

  initial begin
    // Full modulation, one whole reference period.
    mod_idx = 9'd256;
    do_reset();
    repeat (DIV) @(negedge clk);
    check_eq("R1 bridge still off before first update", int'(br_gate), 0);
    repeat (RUN - DIV) @(negedge clk);
    check_eq("R6 peak level at full modulation", maxlvl, 4);
    check_eq("R9 polarity changes per period", toggles, 2);

    // Over-range index clamps to full scale.
    mod_idx = 9'd450;
    do_reset();
    repeat (RUN) @(negedge clk);
    check_eq("R5 clamped index peak level", maxlvl, 4);
    check_eq("R9 polarity changes with clamped index", toggles, 2);

    // Half modulation.
    mod_idx = 9'd128;
    do_reset();
    repeat (RUN) @(negedge clk);
    check_eq("R5 half modulation peak level", maxlvl, 2);

    // Zero modulation keeps the bypass switch on.
    mod_idx = 9'd0;
    do_reset();
    repeat (RUN) @(negedge clk);
    check_eq("R5 zero modulation peak level", maxlvl, 0);
    check_eq("R8 bridge on at zero modulation", int'(br_gate), 9);

    // Index changes every clock: only the value at the tick counts.
    do_reset();
    for (int c = 0; c < RUN; c++) begin
      mod_idx = 9'((c * 37) % 300);
      @(negedge clk);
    end
    check_eq("R9 polarity changes with moving index", toggles, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule